// File: doc/BRIEF.md
# Windowed Watchdog Timer with Configuration Lock

This block is a watchdog. A 16-bit counter advances either on every clock or once every 256 clocks. Software has to service it before the counter reaches a programmed limit. If it does not, the block sets an interrupt flag, and a fixed number of clocks later it raises a reset request that stays high until the next reset. If interrupts are switched off, the reset request comes at once. A window mode is available. In that mode a service that arrives while the counter is still below a programmed window value is treated as a fault, in the same way as a timeout.

Software reaches the block through a small register bus. The bus has a word address, a write strobe with a size code (byte, half-word or word), write data, and combinational read data. Service and unlock commands go to the counter address as key values. Any write there that is not a key, or that has the wrong size, raises the reset request at once.

After reset the configuration stays open for 128 clocks. When that period ends, the configuration either waits to be reopened by an unlock command or, if updates were disallowed, stays frozen until the next reset. Two test modes let the counter be checked one byte at a time. Three inputs can pause counting during stop, wait and debug states. Each pause applies unless a matching enable bit lets counting continue.

Top module: `guard_wdt`

Register map (word address `bus_addr`):
- 0 control/status. Read/write bits:
  - bit 0: enable
  - bit 1: interrupt enable
  - bit 2: window mode
  - bit 3: divide-by-256
  - bit 4: wide command mode
  - bit 5: updates allowed
  - bits 7:6: compare mode
  - bit 8: run in stop
  - bit 9: run in wait
  - bit 10: run in debug

  Bit 12 is the interrupt flag; write 1 to clear it. Bit 13 (read only) is 1 while the configuration is open. Bit 14 (read only) is 1 once a configuration period has closed. The value after reset is 0x0060. Byte writes update bits 7:0 only; half-word and word writes update bits 10:0.
- 1 reads the counter; writes go to the command decoder.
- 2 is the 16-bit limit; its value after reset is 0xFFFF.
- 3 is the 16-bit window value; its value after reset is 0x0000.

Size codes are 0 for byte, 1 for half-word and 2 for word. Keys in half-word mode are 0xC520 then 0xD928 to unlock, and 0xA602 then 0xB480 to service. In wide mode they are 0xD928C520 and 0xB480A602.

Lock state machine:
- LK_OPEN goes to LK_SHUT on timer expiry with updates allowed.
- LK_OPEN goes to LK_FROZEN on timer expiry with updates disallowed.
- LK_SHUT goes to LK_OPEN on an unlock.
- LK_FROZEN is terminal.

Command state machine:
- CK_IDLE goes to CK_UNLK_HALF on 0xC520.
- CK_IDLE goes to CK_SVC_HALF on 0xA602.
- Either half state goes back to CK_IDLE on the next write.
- Wide mode stays in CK_IDLE.

Alarm state machine:
- AL_WATCH goes to AL_NOTIFY on a fault with interrupts enabled.
- AL_WATCH goes to AL_RESET on a fault with interrupts disabled, or on a bad command.
- AL_NOTIFY goes to AL_RESET after 128 clocks, or at once on a bad command.
- AL_RESET holds until reset.

## Requirements
- R1: After reset, control reads 0x2060, the counter reads 0, the limit reads 0xFFFF, the window reads 0, and both `irq` and `rst_req` are low.
- R2: While enabled and running, the counter increments and stops at the first value that matches the limit. Compare modes 0 and 1 compare all 16 bits.
- R3: Compare mode 2 matches on the low byte only, and compare mode 3 matches on the high byte only.
- R4: With divide-by-256 set, the counter advances once per 256 clocks.
- R5: A fault with interrupts enabled sets the flag and raises `irq`. `rst_req` then rises 128 clocks later. With interrupts disabled, `rst_req` rises on the clock after the fault. `rst_req` stays high until reset.
- R6: In half-word mode, the key pair 0xA602, 0xB480 clears the counter to 0.
- R7: With window mode on, a service while the counter is below the window value is a fault. A service at or above the window value is not.
- R8: A non-key value or a wrongly sized write at the command address raises `rst_req` on the next clock without setting the flag.
- R9: In wide mode, the single word 0xB480A602 services the counter, and a half-word command write is a bad command.
- R10: The configuration is open for 128 clocks after reset. After that, bit 13 reads 0, bit 14 reads 1, and writes to the limit are ignored.
- R11: If updates are allowed, the unlock keys reopen the configuration for another 128 clocks. While it is open, bit 13 reads 1, bit 14 reads 0, and writes take effect.
- R12: If updates are disallowed when the open period ends, the unlock keys are ignored and the configuration stays frozen until reset.
- R13: While `lp_stop`, `lp_wait` or `dbg_halt` is high, the counter holds its value unless the matching run bit is set.
- R14: Writing 1 to control bit 12 clears the flag and drops `irq`, and it does not change the configuration bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | Write size: 0 byte, 1 half-word, 2 word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data at `bus_addr` |
| lp_stop | input | 1 | Chip stop state indication |
| lp_wait | input | 1 | Chip wait state indication |
| dbg_halt | input | 1 | Debug halt indication |
| irq | output | 1 | Interrupt: flag set and interrupts enabled |
| rst_req | output | 1 | Sticky reset request |

## Verification
A counter that is held or cleared wrongly shows up within one clock as a wrong value at the counter address. It also shows up as an `irq` that comes too early, too late or never. A wrong step in the command state machine turns a valid key pair into an immediate `rst_req` on the second write, or lets a bad value pass with no reset request. A stuck lock state is visible on the next control read through bits 13 and 14, and on the next limit write read back. A wrong alarm delay shifts the rise of `rst_req` relative to `irq` by a countable number of clocks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [15:0] KEY_UNLK_A = 16'hC520;
    localparam logic [15:0] KEY_UNLK_B = 16'hD928;
    localparam logic [15:0] KEY_SVC_A  = 16'hA602;
    localparam logic [15:0] KEY_SVC_B  = 16'hB480;
    localparam logic [31:0] KEY_UNLK_W = {KEY_UNLK_B, KEY_UNLK_A};
    localparam logic [31:0] KEY_SVC_W  = {KEY_SVC_B, KEY_SVC_A};

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } wsize_t;

    typedef enum logic [1:0] {
        AD_CTRL  = 2'd0,
        AD_COUNT = 2'd1,
        AD_LIMIT = 2'd2,
        AD_WIN   = 2'd3
    } waddr_t;

    typedef enum logic [1:0] {
        CMP_OFF  = 2'd0,
        CMP_USER = 2'd1,
        CMP_LOW  = 2'd2,
        CMP_HIGH = 2'd3
    } cmp_mode_t;

    typedef struct packed {
        logic      run_dbg;
        logic      run_wait;
        logic      run_stop;
        cmp_mode_t mode;
        logic      allow;
        logic      wide;
        logic      presc;
        logic      win_en;
        logic      irq_en;
        logic      en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = 11'h060;

endpackage

// File: rtl/wdt_cmd_decode.sv
module wdt_cmd_decode
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [1:0]  size,
    input  logic [31:0] data,
    input  logic        wide_mode,
    output logic        unlock_p,
    output logic        service_p,
    output logic        bad_p
);

    typedef enum logic [1:0] {
        CK_IDLE,
        CK_UNLK_HALF,
        CK_SVC_HALF
    } ck_state_t;

    ck_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CK_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d      = st_q;
        unlock_p  = 1'b0;
        service_p = 1'b0;
        bad_p     = 1'b0;
        if (cmd_we) begin
            if (wide_mode) begin
                st_d = CK_IDLE;
                if (size != SZ_WORD)          bad_p     = 1'b1;
                else if (data == KEY_UNLK_W)  unlock_p  = 1'b1;
                else if (data == KEY_SVC_W)   service_p = 1'b1;
                else                          bad_p     = 1'b1;
            end else if (size != SZ_HALF) begin
                st_d  = CK_IDLE;
                bad_p = 1'b1;
            end else begin
                unique case (st_q)
                    CK_IDLE: begin
                        if (data[15:0] == KEY_UNLK_A)     st_d  = CK_UNLK_HALF;
                        else if (data[15:0] == KEY_SVC_A) st_d  = CK_SVC_HALF;
                        else                              bad_p = 1'b1;
                    end
                    CK_UNLK_HALF: begin
                        st_d = CK_IDLE;
                        if (data[15:0] == KEY_UNLK_B) unlock_p = 1'b1;
                        else                          bad_p    = 1'b1;
                    end
                    CK_SVC_HALF: begin
                        st_d = CK_IDLE;
                        if (data[15:0] == KEY_SVC_B) service_p = 1'b1;
                        else                         bad_p     = 1'b1;
                    end
                    default: st_d = CK_IDLE;
                endcase
            end
        end
    end

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({unlock_p, service_p, bad_p}) <= 1);                    // R8
    AST_HALF_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CK_IDLE && cmd_we) |=> st_q == CK_IDLE);                   // R6

endmodule

// File: rtl/wdt_lock_ctrl.sv
module wdt_lock_ctrl #(
    parameter int OPEN_CLKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock_p,
    input  logic allow,
    output logic cfg_open,
    output logic reconf_ok
);

    localparam int TW = $clog2(OPEN_CLKS + 1);
    localparam logic [TW-1:0] T_LOAD = TW'(OPEN_CLKS);
    localparam logic [TW-1:0] T_ONE  = TW'(1);

    typedef enum logic [1:0] {
        LK_OPEN,
        LK_SHUT,
        LK_FROZEN
    } lk_state_t;

    lk_state_t      st_q, st_d;
    logic [TW-1:0]  tmr_q, tmr_d;
    logic           ok_q, ok_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LK_OPEN;
            tmr_q <= T_LOAD;
            ok_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            tmr_q <= tmr_d;
            ok_q  <= ok_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        tmr_d = tmr_q;
        ok_d  = ok_q;
        unique case (st_q)
            LK_OPEN: begin
                if (tmr_q == T_ONE) begin
                    st_d = allow ? LK_SHUT : LK_FROZEN;
                    ok_d = 1'b1;
                end else begin
                    tmr_d = tmr_q - T_ONE;
                end
            end
            LK_SHUT: begin
                if (unlock_p && allow) begin
                    st_d  = LK_OPEN;
                    tmr_d = T_LOAD;
                    ok_d  = 1'b0;
                end
            end
            LK_FROZEN: st_d = LK_FROZEN;
            default:   st_d = LK_FROZEN;
        endcase
    end

    always_comb begin
        cfg_open  = (st_q == LK_OPEN);
        reconf_ok = ok_q;
    end

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == LK_FROZEN |=> st_q == LK_FROZEN);                           // R12
    AST_OPEN_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == LK_OPEN |-> (tmr_q != '0 && tmr_q <= T_LOAD));              // R10

endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             presc_en,
    input  logic             clear,
    input  cmp_mode_t        mode,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);

    localparam int HW = CNT_W / 2;
    localparam logic [PRE_W-1:0] PRE_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic             tick;

    always_comb begin
        unique case (mode)
            CMP_LOW:  hit = (cnt_q[HW-1:0] == limit[HW-1:0]);
            CMP_HIGH: hit = (cnt_q[CNT_W-1:HW] == limit[CNT_W-1:HW]);
            default:  hit = (cnt_q == limit);
        endcase
        tick = !presc_en || (pre_q == PRE_MAX);
        cnt  = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (run && !hit) begin
            pre_q <= pre_q + 1'b1;
            if (tick) cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_HOLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(cnt_q));                               // R13
    AST_HOLD_AT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clear) |=> $stable(cnt_q));                                // R2

endmodule

// File: rtl/wdt_alarm_fsm.sv
module wdt_alarm_fsm #(
    parameter int DELAY = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_ev,
    input  logic bad_p,
    input  logic irq_en,
    output logic set_flag,
    output logic rst_req
);

    localparam int DW = $clog2(DELAY);
    localparam logic [DW-1:0] D_LAST = DW'(DELAY - 1);

    typedef enum logic [1:0] {
        AL_WATCH,
        AL_NOTIFY,
        AL_RESET
    } al_state_t;

    al_state_t     st_q, st_d;
    logic [DW-1:0] dly_q, dly_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= AL_WATCH;
            dly_q <= '0;
        end else begin
            st_q  <= st_d;
            dly_q <= dly_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        dly_d    = dly_q;
        set_flag = 1'b0;
        unique case (st_q)
            AL_WATCH: begin
                if (bad_p) begin
                    st_d = AL_RESET;
                end else if (fault_ev) begin
                    if (irq_en) begin
                        st_d     = AL_NOTIFY;
                        dly_d    = '0;
                        set_flag = 1'b1;
                    end else begin
                        st_d = AL_RESET;
                    end
                end
            end
            AL_NOTIFY: begin
                if (bad_p || dly_q == D_LAST) st_d  = AL_RESET;
                else                          dly_d = dly_q + 1'b1;
            end
            AL_RESET: st_d = AL_RESET;
            default:  st_d = AL_RESET;
        endcase
    end

    always_comb rst_req = (st_q == AL_RESET);

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);                                               // R5
    AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == AL_NOTIFY |-> dly_q <= D_LAST);                             // R5
    AST_BAD_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_p |=> rst_req);                                                 // R8

endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRE_W     = 8,
    parameter int OPEN_CLKS = 128,
    parameter int IRQ_DELAY = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        wr_en,
    input  logic [1:0]  wr_size,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        lp_stop,
    input  logic        lp_wait,
    input  logic        dbg_halt,
    output logic        irq,
    output logic        rst_req
);

    localparam int CW = $bits(ctrl_t);
    localparam int FLAG_BIT = 12;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] limit_q, win_q, cnt;
    logic             flag_q;
    logic             cfg_open, reconf_ok;
    logic             unlock_p, service_p, bad_p;
    logic             hit, run, fault_ev, win_viol, set_flag;
    logic             we_ctrl, we_cmd, we_limit, we_win;
    logic [1:0]       lane;

    always_comb begin
        we_ctrl  = wr_en && (bus_addr == AD_CTRL);
        we_cmd   = wr_en && (bus_addr == AD_COUNT);
        we_limit = wr_en && (bus_addr == AD_LIMIT) && cfg_open;
        we_win   = wr_en && (bus_addr == AD_WIN) && cfg_open;
        lane     = (wr_size == SZ_BYTE) ? 2'b01 : 2'b11;
        run      = ctrl_q.en
                 && !(lp_stop  && !ctrl_q.run_stop)
                 && !(lp_wait  && !ctrl_q.run_wait)
                 && !(dbg_halt && !ctrl_q.run_dbg);
        win_viol = service_p && ctrl_q.en && ctrl_q.win_en && (cnt < win_q);
        fault_ev = (run && hit) || win_viol;
        irq      = flag_q && ctrl_q.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            limit_q <= '1;
            win_q   <= '0;
        end else begin
            if (we_ctrl && cfg_open) begin
                if (lane[0]) ctrl_q[7:0]    <= wr_data[7:0];
                if (lane[1]) ctrl_q[CW-1:8] <= wr_data[CW-1:8];
            end
            if (we_limit) begin
                if (lane[0]) limit_q[7:0]       <= wr_data[7:0];
                if (lane[1]) limit_q[CNT_W-1:8] <= wr_data[CNT_W-1:8];
            end
            if (we_win) begin
                if (lane[0]) win_q[7:0]       <= wr_data[7:0];
                if (lane[1]) win_q[CNT_W-1:8] <= wr_data[CNT_W-1:8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          flag_q <= 1'b0;
        else if (set_flag)                                   flag_q <= 1'b1;
        else if (we_ctrl && lane[1] && wr_data[FLAG_BIT])    flag_q <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        unique case (bus_addr)
            AD_CTRL:  rd_data = {17'b0, reconf_ok, cfg_open, flag_q, 1'b0, ctrl_q};
            AD_COUNT: rd_data = 32'(cnt);
            AD_LIMIT: rd_data = 32'(limit_q);
            AD_WIN:   rd_data = 32'(win_q);
            default:  rd_data = '0;
        endcase
    end

    wdt_cmd_decode u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (we_cmd),
        .size      (wr_size),
        .data      (wr_data),
        .wide_mode (ctrl_q.wide),
        .unlock_p  (unlock_p),
        .service_p (service_p),
        .bad_p     (bad_p)
    );

    wdt_lock_ctrl #(.OPEN_CLKS(OPEN_CLKS)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .unlock_p  (unlock_p),
        .allow     (ctrl_q.allow),
        .cfg_open  (cfg_open),
        .reconf_ok (reconf_ok)
    );

    wdt_count_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .presc_en (ctrl_q.presc),
        .clear    (service_p),
        .mode     (ctrl_q.mode),
        .limit    (limit_q),
        .cnt      (cnt),
        .hit      (hit)
    );

    wdt_alarm_fsm #(.DELAY(IRQ_DELAY)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_ev (fault_ev),
        .bad_p    (bad_p),
        .irq_en   (ctrl_q.irq_en),
        .set_flag (set_flag),
        .rst_req  (rst_req)
    );

    AST_LOCKED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == AD_LIMIT && !cfg_open) |=> $stable(limit_q)); // R10
    AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open) |=> $stable(ctrl_q));                                   // R14
    AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        service_p |=> cnt == '0);                                           // R6

endmodule

// File: tb/guard_wdt_tb_top.sv
module guard_wdt_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        lp_stop = 1'b0, lp_wait = 1'b0, dbg_halt = 1'b0;
    logic        irq, rst_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    guard_wdt dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
        .wr_size(wr_size), .wr_data(wr_data), .rd_data(rd_data),
        .lp_stop(lp_stop), .lp_wait(lp_wait), .dbg_halt(dbg_halt),
        .irq(irq), .rst_req(rst_req)
    );

    // {compare mode, limit, expected counter value at the fault}
    localparam logic [33:0] VEC [0:5] = '{
        {2'd1, 16'h0010, 16'h0010},
        {2'd0, 16'h0025, 16'h0025},
        {2'd2, 16'h1234, 16'h0034},
        {2'd3, 16'h0300, 16'h0300},
        {2'd2, 16'h0100, 16'h0000},
        {2'd3, 16'h00FF, 16'h0000}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic restart();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; lp_stop = 1'b0; lp_wait = 1'b0; dbg_halt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; wr_size = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wait_rst(input int lim);
        for (int i = 0; i < lim && !rst_req; i++) @(negedge clk);
    endtask

    task automatic wait_irq(input int lim);
        for (int i = 0; i < lim && !irq; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, a, b;
        int n;

        // R1 reset state
        restart();
        @(negedge clk);
        rd(2'd0, v); chk(v == 32'h2060, "R1 ctrl", v, 32'h2060);
        rd(2'd1, v); chk(v == 0, "R1 count", v, 0);
        rd(2'd2, v); chk(v == 32'hFFFF, "R1 limit", v, 32'hFFFF);
        rd(2'd3, v); chk(v == 0, "R1 window", v, 0);
        chk(!irq && !rst_req, "R1 outputs", {30'b0, irq, rst_req}, 0);

        // R2 / R3 compare modes, walked from the vector table
        for (int k = 0; k < 6; k++) begin
            restart();
            wr(2'd2, 2'd2, {16'b0, VEC[k][31:16]});
            wr(2'd0, 2'd2, {24'b0, VEC[k][33:32], 6'b100001});
            wait_rst(2000);
            rd(2'd1, v);
            chk(v == {16'b0, VEC[k][15:0]}, (VEC[k][33:32] >= 2) ? "R3 byte compare" : "R2 full compare",
                v, {16'b0, VEC[k][15:0]});
            chk(rst_req && !irq, "R5 no irq path", {30'b0, irq, rst_req}, 1);
        end

        // R5 interrupt then delayed reset request
        restart();
        wr(2'd2, 2'd1, 32'h0020);
        wr(2'd0, 2'd1, 32'h0063);
        wait_irq(500);
        chk(irq && !rst_req, "R5 irq first", {30'b0, irq, rst_req}, 2);
        n = 0;
        while (!rst_req && n < 400) begin n++; @(negedge clk); end
        chk(n == 128, "R5 delay", n, 128);
        repeat (5) @(negedge clk);
        chk(rst_req, "R5 sticky", {31'b0, rst_req}, 1);

        // R6 half-word service keeps it alive
        restart();
        wr(2'd2, 2'd1, 32'd60);
        wr(2'd0, 2'd1, 32'h0063);
        for (int k = 0; k < 6; k++) begin
            repeat (40) @(negedge clk);
            wr(2'd1, 2'd1, 32'hA602);
            wr(2'd1, 2'd1, 32'hB480);
        end
        rd(2'd1, v); chk(v <= 1, "R6 cleared", v, 0);
        chk(!irq && !rst_req, "R6 alive", {30'b0, irq, rst_req}, 0);

        // R7 window mode
        restart();
        wr(2'd3, 2'd1, 32'd30);
        wr(2'd2, 2'd1, 32'd1000);
        wr(2'd0, 2'd1, 32'h0067);
        repeat (60) @(negedge clk);
        wr(2'd1, 2'd1, 32'hA602);
        wr(2'd1, 2'd1, 32'hB480);
        chk(!irq, "R7 late service ok", {31'b0, irq}, 0);
        wr(2'd1, 2'd1, 32'hA602);
        wr(2'd1, 2'd1, 32'hB480);
        @(negedge clk);
        chk(irq && !rst_req, "R7 early service fault", {30'b0, irq, rst_req}, 2);

        // R8 bad command value
        restart();
        wr(2'd2, 2'd1, 32'd1000);
        wr(2'd0, 2'd1, 32'h0063);
        repeat (10) @(negedge clk);
        chk(!rst_req, "R8 before", {31'b0, rst_req}, 0);
        wr(2'd1, 2'd1, 32'h1111);
        chk(rst_req && !irq, "R8 immediate", {30'b0, irq, rst_req}, 1);

        // R9 wide command mode
        restart();
        wr(2'd2, 2'd1, 32'd1000);
        wr(2'd0, 2'd1, 32'h0071);
        repeat (50) @(negedge clk);
        wr(2'd1, 2'd2, 32'hB480A602);
        rd(2'd1, v); chk(v <= 1, "R9 wide service", v, 0);
        chk(!rst_req, "R9 no reset", {31'b0, rst_req}, 0);
        wr(2'd1, 2'd1, 32'h0000A602);
        chk(rst_req, "R9 half in wide", {31'b0, rst_req}, 1);

        // R10 / R11 lock and reopen
        restart();
        wr(2'd0, 2'd1, 32'h0060);
        wr(2'd2, 2'd1, 32'h0100);
        repeat (130) @(negedge clk);
        rd(2'd0, v); chk(v[14:13] == 2'b10, "R10 locked status", v[14:13], 2);
        wr(2'd2, 2'd1, 32'h0222);
        rd(2'd2, v); chk(v == 32'h0100, "R10 write ignored", v, 32'h0100);
        wr(2'd1, 2'd1, 32'hC520);
        wr(2'd1, 2'd1, 32'hD928);
        rd(2'd0, v); chk(v[14:13] == 2'b01, "R11 reopened status", v[14:13], 1);
        wr(2'd2, 2'd1, 32'h0222);
        rd(2'd2, v); chk(v == 32'h0222, "R11 write taken", v, 32'h0222);
        repeat (130) @(negedge clk);
        rd(2'd0, v); chk(v[14:13] == 2'b10, "R11 closes again", v[14:13], 2);

        // R12 freeze
        restart();
        wr(2'd0, 2'd1, 32'h0040);
        wr(2'd2, 2'd1, 32'h0100);
        repeat (130) @(negedge clk);
        wr(2'd1, 2'd1, 32'hC520);
        wr(2'd1, 2'd1, 32'hD928);
        rd(2'd0, v); chk(v[13] == 1'b0, "R12 unlock ignored", v[13], 0);
        wr(2'd2, 2'd1, 32'h0333);
        rd(2'd2, v); chk(v == 32'h0100, "R12 frozen limit", v, 32'h0100);
        chk(!rst_req, "R12 no reset", {31'b0, rst_req}, 0);

        // R4 prescaler
        restart();
        wr(2'd2, 2'd1, 32'h0010);
        wr(2'd0, 2'd1, 32'h0069);
        repeat (300) @(negedge clk);
        rd(2'd1, v); chk(v == 1, "R4 divided count", v, 1);

        // R13 low-power gating
        restart();
        wr(2'd2, 2'd1, 32'd1000);
        wr(2'd0, 2'd1, 32'h0461);
        repeat (5) @(negedge clk);
        lp_stop = 1'b1;
        @(negedge clk); rd(2'd1, a);
        repeat (50) @(negedge clk);
        rd(2'd1, b); chk(a == b, "R13 stop holds", b, a);
        lp_stop = 1'b0; dbg_halt = 1'b1;
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk(v > b, "R13 debug runs", v, b + 20);
        dbg_halt = 1'b0; lp_wait = 1'b1;
        @(negedge clk); rd(2'd1, a);
        repeat (30) @(negedge clk);
        rd(2'd1, b); chk(a == b, "R13 wait holds", b, a);
        lp_wait = 1'b0;

        // R14 flag clear by writing one
        restart();
        wr(2'd2, 2'd1, 32'd300);
        wr(2'd0, 2'd1, 32'h0063);
        wait_irq(1000);
        rd(2'd0, v); chk(v[12] && v[13] == 1'b0, "R14 flag set", v, 32'h1000);
        wr(2'd0, 2'd2, 32'h0000_1000);
        rd(2'd0, v);
        chk(v[12] == 1'b0 && v[10:0] == 11'h063, "R14 cleared, config kept", v, 32'h4063);
        chk(!irq, "R14 irq low", {31'b0, irq}, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule